// File: doc/BRIEF.md
# DRAM Rank Power State Controller

This block decides, for each rank of one DDR3 memory channel, whether the rank runs with its clock enable high or sits in one of three low-power conditions. Each rank has its own idle-cycle counter. When the counter sees a programmed number of consecutive cycles with no command request, the rank leaves the active state. The low-power condition it enters depends on two things: whether any bank of that rank is still open, and whether the package-level idle policy currently permits self-refresh.

Self-refresh is permitted only in the two deepest package idle states, and only while the integrated graphics engine is idle, no display fetch is pending and a single display is being driven. In every other package state the ranks use only dynamic power-down. Self-refresh ends as soon as that permission is withdrawn. The rank then raises its clock enable at once, but it reports itself ready for commands only after a programmed exit delay has elapsed.

Ranks that are not populated have their pad drivers disabled and their clock enable and ready outputs held low.

Top module: `rank_pwr_ctl`

## Requirements
- R1: After reset every populated rank is in the active state (state code 0), with clock enable high, ready high and pad output enable high.
- R2: With `idle_limit` = L > 0, a rank that sees no command request leaves the active state on the L-th consecutive idle clock edge. A command request in the active state restarts the count. With L = 0 the rank never powers down on idleness.
- R3: On idle timeout without self-refresh permission, a rank with `bank_open` high enters active power-down (code 2), and a rank with all banks closed enters precharge power-down (code 1). Clock enable and ready are low in both.
- R4: A command request in either power-down state returns the rank to the active state on the next clock edge, with clock enable and ready high. Ready is never high while clock enable is low.
- R5: Self-refresh permission holds exactly when `pkg_state` is 3 (C3) or 4 (C6), `gfx_idle` is high, `disp_pending` is low and `single_display` is high. Codes 0, 1 and 2 stand for C0, C1 and C1E, and codes 5 to 7 are treated like shallow states. An idle timeout with permission and all banks closed enters self-refresh (code 3) with clock enable low. Otherwise R3 applies.
- R6: A rank in precharge power-down moves to self-refresh on the first clock edge at which self-refresh permission holds.
- R7: When permission is withdrawn, a rank in self-refresh moves on the next edge to the exit state (code 4). In the exit state clock enable is high and ready is low. The rank stays there for max(`exit_delay`, 1) cycles and then returns to the active state.
- R8: A command request has no effect on a rank in self-refresh: the rank stays in code 3 with clock enable low.
- R9: A rank whose `rank_present` bit is low has pad output enable, clock enable and ready all low. Its command requests have no effect.
- R10: Ranks are independent: the requests and bank status of one rank do not change the state of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rank_present | input | NUM_RANKS | Rank populated flags |
| idle_limit | input | IDLE_W | Idle cycles before power-down; 0 disables |
| exit_delay | input | EXIT_W | Cycles from self-refresh exit start to ready |
| cmd_req | input | NUM_RANKS | Pending command request per rank |
| bank_open | input | NUM_RANKS | At least one bank open, per rank |
| pkg_state | input | 3 | Package idle state code (see R5) |
| gfx_idle | input | 1 | Integrated graphics engine idle |
| disp_pending | input | 1 | Display requests outstanding |
| single_display | input | 1 | Exactly one display active |
| cke | output | NUM_RANKS | Clock enable per rank |
| pad_oe | output | NUM_RANKS | Output enable of the rank's command pads (low = tri-state) |
| cmd_ready | output | NUM_RANKS | Rank may accept a command |
| rank_state | output | 3*NUM_RANKS | State code per rank, rank 0 in the low bits |

## Verification
The idle threshold is swept over several values with banks open and closed. This separates off-by-one errors in the timeout from wrong choices between the two power-down kinds. The self-refresh policy is tried over every package code, every combination of the three graphics and display flags, and both bank conditions. That sweep shows that each gate of the permission is needed and that the bank check overrides it. The exit delay is swept from zero upward, so that the zero-delay clamp is told apart from a normal count. Separate runs cover a wake that follows a restarted idle count, requests made during self-refresh, and a rank that is removed while the other keeps working.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  typedef enum logic [2:0] {
    RS_ACT = 3'd0,
    RS_PPD = 3'd1,
    RS_APD = 3'd2,
    RS_SR  = 3'd3,
    RS_SRX = 3'd4
  } rank_st_e;

  localparam logic [2:0] PKG_DEEP_A = 3'd3;
  localparam logic [2:0] PKG_DEEP_B = 3'd4;

  function automatic logic pkg_is_deep(input logic [2:0] s);
    return (s == PKG_DEEP_A) || (s == PKG_DEEP_B);
  endfunction

endpackage

// File: rtl/rank_sr_policy.sv
module rank_sr_policy
  import rank_pwr_pkg::*;
(
  input  logic [2:0] pkg_state,
  input  logic       gfx_idle,
  input  logic       disp_pending,
  input  logic       single_display,
  output logic       sr_ok
);

  logic deep;

  always_comb begin
    deep  = pkg_is_deep(pkg_state);
    sr_ok = deep & gfx_idle & ~disp_pending & single_display;
  end

endmodule

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int EXIT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present,
  input  logic              cmd_req,
  input  logic              bank_open,
  input  logic              sr_ok,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [EXIT_W-1:0] exit_delay,
  output logic [2:0]        state_o,
  output logic              cke_o,
  output logic              ready_o
);

  localparam int CNT_W = (IDLE_W > EXIT_W) ? IDLE_W : EXIT_W;

  rank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   lim_w;
  logic [CNT_W:0]   dly_w;
  logic             cnt_sat;
  logic             in_sr, in_apd, in_pd;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    lim_w   = (CNT_W+1)'(idle_limit);
    dly_w   = (CNT_W+1)'(exit_delay);
    cnt_sat = &cnt_q;
  end

  // next-state process
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      RS_ACT: begin
        if (cmd_req) begin
          cnt_d = '0;
        end else if ((lim_w != '0) && (cnt_inc == lim_w)) begin
          cnt_d = '0;
          if (sr_ok && !bank_open) st_d = RS_SR;
          else if (bank_open)      st_d = RS_APD;
          else                     st_d = RS_PPD;
        end else if (!cnt_sat) begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      RS_PPD: begin
        if (cmd_req)                    st_d = RS_ACT;
        else if (sr_ok && !bank_open)   st_d = RS_SR;
      end
      RS_APD: begin
        if (cmd_req) st_d = RS_ACT;
      end
      RS_SR: begin
        cnt_d = '0;
        if (!sr_ok) st_d = RS_SRX;
      end
      RS_SRX: begin
        if (cnt_inc >= dly_w) begin
          st_d  = RS_ACT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
      default: begin
        st_d  = RS_ACT;
        cnt_d = '0;
      end
    endcase
    if (!present) begin
      st_d  = RS_ACT;
      cnt_d = '0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_ACT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    state_o = st_q;
    cke_o   = (st_q == RS_ACT) || (st_q == RS_SRX);
    ready_o = (st_q == RS_ACT);
    in_sr   = (st_q == RS_SR);
    in_apd  = (st_q == RS_APD);
    in_pd   = (st_q == RS_PPD) || (st_q == RS_APD);
  end

  // R4: a request in power-down wakes the rank on the next edge
  a_r4_wake: assert property (@(posedge clk) disable iff (!rst_n)
    present && in_pd && cmd_req |=> (st_q == RS_ACT) && cke_o);

  // R5: self-refresh is entered only with permission and closed banks
  a_r5_sr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sr) |-> $past(sr_ok && !bank_open));

  // R3: active power-down is entered only with an open bank
  a_r3_apd_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_apd) |-> $past(bank_open));

  // R8: self-refresh holds while permission holds, whatever the requests
  a_r8_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    present && in_sr && sr_ok |=> in_sr && !cke_o);

  // R7: loss of permission starts the exit sequence
  a_r7_sr_exit: assert property (@(posedge clk) disable iff (!rst_n)
    present && in_sr && !sr_ok |=> (st_q == RS_SRX) && cke_o && !ready_o);

endmodule

// File: rtl/rank_pad_gate.sv
module rank_pad_gate #(
  parameter int NUM_RANKS = 2
) (
  input  logic [NUM_RANKS-1:0] present,
  input  logic [NUM_RANKS-1:0] cke_int,
  input  logic [NUM_RANKS-1:0] ready_int,
  output logic [NUM_RANKS-1:0] cke,
  output logic [NUM_RANKS-1:0] pad_oe,
  output logic [NUM_RANKS-1:0] ready
);

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_gate
    always_comb begin
      pad_oe[g] = present[g];
      cke[g]    = present[g] & cke_int[g];
      ready[g]  = present[g] & ready_int[g];
    end
  end

endmodule

// File: rtl/rank_pwr_ctl.sv
module rank_pwr_ctl
  import rank_pwr_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int IDLE_W    = 8,
  parameter int EXIT_W    = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_RANKS-1:0]   rank_present,
  input  logic [IDLE_W-1:0]      idle_limit,
  input  logic [EXIT_W-1:0]      exit_delay,
  input  logic [NUM_RANKS-1:0]   cmd_req,
  input  logic [NUM_RANKS-1:0]   bank_open,
  input  logic [2:0]             pkg_state,
  input  logic                   gfx_idle,
  input  logic                   disp_pending,
  input  logic                   single_display,
  output logic [NUM_RANKS-1:0]   cke,
  output logic [NUM_RANKS-1:0]   pad_oe,
  output logic [NUM_RANKS-1:0]   cmd_ready,
  output logic [3*NUM_RANKS-1:0] rank_state
);

  logic                 sr_ok;
  logic [NUM_RANKS-1:0] cke_int;
  logic [NUM_RANKS-1:0] ready_int;

  rank_sr_policy u_policy (
    .pkg_state      (pkg_state),
    .gfx_idle       (gfx_idle),
    .disp_pending   (disp_pending),
    .single_display (single_display),
    .sr_ok          (sr_ok)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [2:0] st_w;

    rank_pwr_fsm #(
      .IDLE_W (IDLE_W),
      .EXIT_W (EXIT_W)
    ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .present    (rank_present[r]),
      .cmd_req    (cmd_req[r]),
      .bank_open  (bank_open[r]),
      .sr_ok      (sr_ok),
      .idle_limit (idle_limit),
      .exit_delay (exit_delay),
      .state_o    (st_w),
      .cke_o      (cke_int[r]),
      .ready_o    (ready_int[r])
    );

    assign rank_state[r*3 +: 3] = st_w;

    // R4: ready only with clock enable high
    a_r4_ready_cke: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready[r] |-> cke[r]);

    // R9: an absent rank is parked in the active code on the next edge
    a_r9_absent_park: assert property (@(posedge clk) disable iff (!rst_n)
      !rank_present[r] |=> (st_w == 3'(RS_ACT)));
  end

  rank_pad_gate #(
    .NUM_RANKS (NUM_RANKS)
  ) u_gate (
    .present   (rank_present),
    .cke_int   (cke_int),
    .ready_int (ready_int),
    .cke       (cke),
    .pad_oe    (pad_oe),
    .ready     (cmd_ready)
  );

endmodule

// File: tb/rank_pwr_ctl_bench.sv
module rank_pwr_ctl_bench;

  logic       clk;
  logic       rst_n;
  logic [1:0] rank_present;
  logic [7:0] idle_limit;
  logic [5:0] exit_delay;
  logic [1:0] cmd_req;
  logic [1:0] bank_open;
  logic [2:0] pkg_state;
  logic       gfx_idle;
  logic       disp_pending;
  logic       single_display;
  logic [1:0] cke;
  logic [1:0] pad_oe;
  logic [1:0] cmd_ready;
  logic [5:0] rank_state;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  rank_pwr_ctl u_rank_pwr_ctl (
    .clk            (clk),
    .rst_n          (rst_n),
    .rank_present   (rank_present),
    .idle_limit     (idle_limit),
    .exit_delay     (exit_delay),
    .cmd_req        (cmd_req),
    .bank_open      (bank_open),
    .pkg_state      (pkg_state),
    .gfx_idle       (gfx_idle),
    .disp_pending   (disp_pending),
    .single_display (single_display),
    .cke            (cke),
    .pad_oe         (pad_oe),
    .cmd_ready      (cmd_ready),
    .rank_state     (rank_state)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rank_present = 2'b11; idle_limit = 8'd0; exit_delay = 6'd2;
    cmd_req = 2'b00; bank_open = 2'b00; pkg_state = 3'd0;
    gfx_idle = 1'b0; disp_pending = 1'b0; single_display = 1'b1;

    // R1: reset state
    do_reset();
    step(1);
    chk("R1 state0", rank_state[2:0], 0);
    chk("R1 state1", rank_state[5:3], 0);
    chk("R1 cke", cke, 3);
    chk("R1 ready", cmd_ready, 3);
    chk("R1 oe", pad_oe, 3);

    // R2/R3/R10: timeout sweep, rank 1 kept busy
    for (int l = 1; l <= 5; l++) begin
      for (int b = 0; b < 2; b++) begin
        idle_limit = 8'(l); bank_open = {1'b0, 1'(b)}; cmd_req = 2'b10;
        do_reset();
        step(l - 1);
        chk("R2 before timeout", rank_state[2:0], 0);
        step(1);
        chk("R3 pd kind", rank_state[2:0], b ? 2 : 1);
        chk("R3 cke low", cke[0], 0);
        chk("R3 ready low", cmd_ready[0], 0);
        chk("R10 other rank active", rank_state[5:3], 0);
      end
    end
    idle_limit = 8'd0; cmd_req = 2'b00; bank_open = 2'b00;
    do_reset();
    step(20);
    chk("R2 limit zero", rank_state[2:0], 0);

    // R2 restart + R4 wake from both power-down kinds
    idle_limit = 8'd3; cmd_req = 2'b10;
    do_reset();
    step(2);
    cmd_req[0] = 1'b1; step(1); cmd_req[0] = 1'b0;
    step(2);
    chk("R2 count restarted", rank_state[2:0], 0);
    step(1);
    chk("R2 timeout after restart", rank_state[2:0], 1);
    cmd_req[0] = 1'b1; step(1); cmd_req[0] = 1'b0;
    chk("R4 wake from ppd", rank_state[2:0], 0);
    chk("R4 cke", cke[0], 1);
    chk("R4 ready", cmd_ready[0], 1);
    bank_open = 2'b01;
    do_reset();
    step(3);
    chk("R3 apd", rank_state[2:0], 2);
    cmd_req[0] = 1'b1; step(1); cmd_req[0] = 1'b0;
    chk("R4 wake from apd", rank_state[2:0], 0);
    bank_open = 2'b00;

    // R5: policy sweep
    idle_limit = 8'd2; cmd_req = 2'b10;
    for (int p = 0; p < 8; p++) begin
      for (int f = 0; f < 8; f++) begin
        for (int b = 0; b < 2; b++) begin
          bit ok;
          pkg_state = 3'(p); gfx_idle = f[0]; disp_pending = f[1];
          single_display = f[2]; bank_open = {1'b0, 1'(b)};
          ok = (p == 3 || p == 4) && f[0] && !f[1] && f[2] && (b == 0);
          do_reset();
          step(2);
          chk("R5 policy", rank_state[2:0], ok ? 3 : (b ? 2 : 1));
          chk("R5 cke low", cke[0], 0);
        end
      end
    end

    // R6: precharge power-down to self-refresh
    pkg_state = 3'd0; gfx_idle = 1'b1; disp_pending = 1'b0;
    single_display = 1'b1; bank_open = 2'b00;
    do_reset();
    step(2);
    chk("R6 ppd first", rank_state[2:0], 1);
    pkg_state = 3'd4;
    step(1);
    chk("R6 into sr", rank_state[2:0], 3);

    // R8: requests ignored in self-refresh
    cmd_req[0] = 1'b1;
    step(3);
    chk("R8 sr held", rank_state[2:0], 3);
    chk("R8 cke low", cke[0], 0);
    cmd_req[0] = 1'b0;

    // R7: exit delay sweep
    for (int d = 0; d <= 4; d++) begin
      int span;
      span = (d < 1) ? 1 : d;
      exit_delay = 6'(d); idle_limit = 8'd1; pkg_state = 3'd3;
      do_reset();
      step(1);
      chk("R7 in sr", rank_state[2:0], 3);
      pkg_state = 3'd0;
      for (int k = 0; k < span; k++) begin
        step(1);
        chk("R7 exit state", rank_state[2:0], 4);
        chk("R7 exit cke", cke[0], 1);
        chk("R7 exit ready", cmd_ready[0], 0);
      end
      step(1);
      chk("R7 back active", rank_state[2:0], 0);
      chk("R7 ready", cmd_ready[0], 1);
    end
    exit_delay = 6'd2; pkg_state = 3'd3;
    do_reset();
    step(1);
    disp_pending = 1'b1;
    step(1);
    chk("R7 exit on display work", rank_state[2:0], 4);
    disp_pending = 1'b0;

    // R9: absent rank
    pkg_state = 3'd0; idle_limit = 8'd0;
    do_reset();
    rank_present = 2'b01; cmd_req = 2'b10;
    step(2);
    chk("R9 oe", pad_oe, 1);
    chk("R9 cke", cke[1], 0);
    chk("R9 ready", cmd_ready[1], 0);
    chk("R9 present rank fine", cmd_ready[0], 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule